// File: doc/BRIEF.md
# I2C Byte Buffer with Transmit/Receive Handshake

This block sits between a processor-facing register port and the bit shifter of a multi-master I2C controller. It keeps one byte waiting to be sent and one byte that has arrived. For each it keeps a flag: the transmit side shows whether the waiting byte has already been taken, and the receive side shows whether an unread byte is present. The processor writes a byte to make the transmit slot full, and reads the receive slot to make it empty. The shifter's events fill and empty the slots from the other side.

The block decides when the waiting byte is handed to the output shifter, and the rule depends on the role of the controller. As a slave, the byte is handed over on an address hit that comes with a read request. It is also handed over when a byte has finished shifting and the remote master acknowledged it. As a master, it is handed over at the start of a byte, and only if the processor has supplied a fresh byte. A received byte that arrives while the previous one is still unread does not replace it; the block flags an overrun instead. While the module enable is low, every stimulus is ignored.

Top module: `i2cByteBuf`

## Requirements
- R1: After reset `txEmpty`=1, `rxFull`=0, `shiftLoad`=0, `rxOverrun`=0, `shiftData`=0xFF, and the transmit byte holds 0xFF. A slave handover before any write therefore delivers 0xFF.
- R2: An enabled `cpuWrEn` stores `cpuWrData` and drives `txEmpty` to 0 in the next cycle.
- R3: In slave mode (`masterMode`=0), `addrHit`=1 with `rwRead`=1 causes a handover. In the next cycle `shiftLoad` pulses for one cycle, `shiftData` carries the stored byte, and `txEmpty` becomes 1.
- R4: In slave mode, `byteDone`=1 with `rxAckBit`=0 (ACK) causes a handover. `byteDone` with `rxAckBit`=1 (NACK) causes none and leaves `txEmpty` unchanged.
- R5: In master mode (`masterMode`=1), a handover happens on `byteStart` only when `txEmpty`=0. The slave triggers are ignored in master mode, and `byteStart` is ignored in slave mode.
- R6: If a write and a handover fall in the same cycle, `shiftData` gets the old byte, the new byte is kept, and `txEmpty` ends at 0.
- R7: An enabled `rxValid` while `rxFull`=0 stores `rxByte` into `rxData` and sets `rxFull` in the next cycle.
- R8: An enabled `cpuRdEn` clears `rxFull` in the next cycle, unless R7 stores a byte in the same cycle.
- R9: An enabled `rxValid` while `rxFull`=1 keeps `rxData` unchanged and pulses `rxOverrun` for one cycle in the next cycle.
- R10: While `modEn`=0, writes, reads, handover triggers and received bytes have no effect on any output or stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modEn | input | 1 | Module enable |
| masterMode | input | 1 | 1 = master role, 0 = slave role |
| cpuWrEn | input | 1 | Processor write strobe for the transmit byte |
| cpuWrData | input | 8 | Processor write data |
| cpuRdEn | input | 1 | Processor read strobe for the receive byte |
| addrHit | input | 1 | Own address matched this cycle (slave) |
| rwRead | input | 1 | Remote master requests data (1 = read) |
| rxAckBit | input | 1 | Acknowledge bit returned by the receiver (0 = ACK) |
| byteDone | input | 1 | Pulse: a byte has finished shifting out |
| byteStart | input | 1 | Pulse: master is starting a new byte |
| rxValid | input | 1 | Pulse: the input shifter has a complete byte |
| rxByte | input | 8 | Byte from the input shifter |
| txEmpty | output | 1 | Transmit slot empty flag |
| rxFull | output | 1 | Receive slot full flag |
| rxData | output | 8 | Stored received byte |
| shiftLoad | output | 1 | Pulse: `shiftData` is handed to the output shifter |
| shiftData | output | 8 | Byte handed to the output shifter |
| rxOverrun | output | 1 | Pulse: a received byte was dropped |

## Verification
The bound checker watches several rules on every cycle. A write empties the transmit flag. A handover sets the flag unless a write collides with it. A master handover never takes an empty slot. A NACK never produces a handover. A store raises the receive flag with the right byte, an overrun leaves the stored byte alone, and a disabled cycle changes nothing. Some effects appear only in the bench's scenarios, because they need a byte to be followed from one port to another over several cycles. These are the byte value of a collision and the 0xFF handed over straight after reset. The bench also compares every output against its reference model under random and mixed traffic.

// File: rtl/i2cBufPkg.sv
package i2cBufPkg;
  // Strobes from the control part to the datapath, valid for one cycle
  typedef struct packed {
    logic txWrite;   // capture processor byte
    logic txLoad;    // hand stored byte to output shifter
    logic rxStore;   // capture received byte
    logic rxOvr;     // received byte dropped
  } bufStrobes_t;
endpackage

// File: rtl/i2cBufCtrl.sv
module i2cBufCtrl
  import i2cBufPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modEn,
  input  logic        masterMode,
  input  logic        cpuWrEn,
  input  logic        cpuRdEn,
  input  logic        addrHit,
  input  logic        rwRead,
  input  logic        rxAckBit,
  input  logic        byteDone,
  input  logic        byteStart,
  input  logic        rxValid,
  output bufStrobes_t strobes,
  output logic        txEmpty,
  output logic        rxFull
);
  logic slaveLoad, masterLoad, rdClear;

  always_comb begin
    slaveLoad  = (addrHit && rwRead) || (byteDone && !rxAckBit);
    masterLoad = byteStart && !txEmpty;
    strobes.txWrite = modEn && cpuWrEn;
    strobes.txLoad  = modEn && (masterMode ? masterLoad : slaveLoad);
    strobes.rxStore = modEn && rxValid && !rxFull;
    strobes.rxOvr   = modEn && rxValid && rxFull;
    rdClear         = modEn && cpuRdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
      rxFull  <= 1'b0;
    end else begin
      if (strobes.txWrite)     txEmpty <= 1'b0;
      else if (strobes.txLoad) txEmpty <= 1'b1;
      if (strobes.rxStore)     rxFull  <= 1'b1;
      else if (rdClear)        rxFull  <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cBufData.sv
module i2cBufData
  import i2cBufPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       strobes,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] shiftData,
  output logic              shiftLoad,
  output logic              rxOverrun
);
  localparam logic [DATA_W-1:0] TX_INIT = {DATA_W{1'b1}};
  logic [DATA_W-1:0] txHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold    <= TX_INIT;
      rxData    <= '0;
      shiftData <= TX_INIT;
      shiftLoad <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      shiftLoad <= strobes.txLoad;
      rxOverrun <= strobes.rxOvr;
      if (strobes.txLoad)  shiftData <= txHold;
      if (strobes.txWrite) txHold    <= cpuWrData;
      if (strobes.rxStore) rxData    <= rxByte;
    end
  end
endmodule

// File: rtl/i2cByteBuf.sv
module i2cByteBuf
  import i2cBufPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modEn,
  input  logic              masterMode,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRdEn,
  input  logic              addrHit,
  input  logic              rwRead,
  input  logic              rxAckBit,
  input  logic              byteDone,
  input  logic              byteStart,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  output logic              txEmpty,
  output logic              rxFull,
  output logic [DATA_W-1:0] rxData,
  output logic              shiftLoad,
  output logic [DATA_W-1:0] shiftData,
  output logic              rxOverrun
);
  bufStrobes_t strobes;

  i2cBufCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .modEn(modEn), .masterMode(masterMode),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .addrHit(addrHit), .rwRead(rwRead),
    .rxAckBit(rxAckBit), .byteDone(byteDone), .byteStart(byteStart),
    .rxValid(rxValid), .strobes(strobes), .txEmpty(txEmpty), .rxFull(rxFull)
  );

  i2cBufData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuWrData(cpuWrData),
    .rxByte(rxByte), .rxData(rxData), .shiftData(shiftData),
    .shiftLoad(shiftLoad), .rxOverrun(rxOverrun)
  );
endmodule

// File: rtl/i2cByteBufChk.sv
module i2cByteBufChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              modEn,
  input logic              masterMode,
  input logic              cpuWrEn,
  input logic [DATA_W-1:0] cpuWrData,
  input logic              cpuRdEn,
  input logic              addrHit,
  input logic              rwRead,
  input logic              rxAckBit,
  input logic              byteDone,
  input logic              byteStart,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxByte,
  input logic              txEmpty,
  input logic              rxFull,
  input logic [DATA_W-1:0] rxData,
  input logic              shiftLoad,
  input logic [DATA_W-1:0] shiftData,
  input logic              rxOverrun
);
  p_write_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && cpuWrEn) |=> !txEmpty);

  p_load_sets_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
    (shiftLoad && !$past(modEn && cpuWrEn)) |-> txEmpty);

  p_nack_no_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && !masterMode && byteDone && rxAckBit && !(addrHit && rwRead)) |=> !shiftLoad);

  p_master_needs_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && masterMode && txEmpty && !cpuWrEn) |=> !shiftLoad);

  p_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && rxValid && !rxFull) |=> (rxFull && rxData == $past(rxByte)));

  p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |-> $stable(rxData));

  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |=> ($stable(txEmpty) && $stable(rxFull) && $stable(rxData)
                && !shiftLoad && !rxOverrun));
endmodule

bind i2cByteBuf i2cByteBufChk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/i2cByteBuf_tb.sv
module i2cByteBuf_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modEn = 0, masterMode = 0, cpuWrEn = 0, cpuRdEn = 0;
  logic addrHit = 0, rwRead = 0, rxAckBit = 0, byteDone = 0, byteStart = 0, rxValid = 0;
  logic [7:0] cpuWrData = 0, rxByte = 0;
  logic txEmpty, rxFull, shiftLoad, rxOverrun;
  logic [7:0] rxData, shiftData;

  int nChecks = 0, nFails = 0;
  logic mTxEmpty, mRxFull, mLoad, mOvr;
  logic [7:0] mTx, mRx, mShift;

  always #4 clk = ~clk;  // 125 MHz

  i2cByteBuf u_dut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    mTxEmpty = 1; mRxFull = 0; mLoad = 0; mOvr = 0;
    mTx = 8'hFF; mRx = 8'h00; mShift = 8'hFF;
  endfunction

  // reference model, advanced once per clock with the inputs of that cycle
  function automatic void modelStep();
    logic ld, wr, st, ov, rd;
    wr = modEn && cpuWrEn;
    ld = modEn && (masterMode ? (byteStart && !mTxEmpty)
                              : ((addrHit && rwRead) || (byteDone && !rxAckBit)));
    st = modEn && rxValid && !mRxFull;
    ov = modEn && rxValid && mRxFull;
    rd = modEn && cpuRdEn;
    mLoad = ld;
    if (ld) mShift = mTx;
    if (wr) begin mTxEmpty = 0; mTx = cpuWrData; end
    else if (ld) mTxEmpty = 1;
    if (st) begin mRx = rxByte; mRxFull = 1; end
    else if (rd) mRxFull = 0;
    mOvr = ov;
  endfunction

  task automatic compareAll();
    check("R2 txEmpty", {7'd0, txEmpty}, {7'd0, mTxEmpty});
    check("R3 shiftLoad", {7'd0, shiftLoad}, {7'd0, mLoad});
    check("R6 shiftData", shiftData, mShift);
    check("R8 rxFull", {7'd0, rxFull}, {7'd0, mRxFull});
    check("R7 rxData", rxData, mRx);
    check("R9 rxOverrun", {7'd0, rxOverrun}, {7'd0, mOvr});
  endtask

  // inputs already set at a negedge; clock once, update model, compare
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    modelStep();
    compareAll();
  endtask

  task automatic idle();
    cpuWrEn = 0; cpuRdEn = 0; addrHit = 0; rwRead = 0; rxAckBit = 0;
    byteDone = 0; byteStart = 0; rxValid = 0;
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h1C0FFEE;
    void'($urandom(seed));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    modEn = 1;
    // R1 reset state
    check("R1 txEmpty", {7'd0, txEmpty}, 8'd1);
    check("R1 rxFull", {7'd0, rxFull}, 8'd0);
    check("R1 shiftLoad", {7'd0, shiftLoad}, 8'd0);
    check("R1 rxOverrun", {7'd0, rxOverrun}, 8'd0);
    // R1/R3: slave read handover with no write delivers 0xFF
    addrHit = 1; rwRead = 1; step(); idle();
    check("R1 shiftData", shiftData, 8'hFF);
    check("R3 shiftLoad", {7'd0, shiftLoad}, 8'd1);
    // R2: write
    cpuWrData = 8'h5A; cpuWrEn = 1; step(); idle();
    check("R2 txEmpty", {7'd0, txEmpty}, 8'd0);
    // R4: NACK does nothing
    byteDone = 1; rxAckBit = 1; step(); idle();
    check("R4 nack shiftLoad", {7'd0, shiftLoad}, 8'd0);
    check("R4 nack txEmpty", {7'd0, txEmpty}, 8'd0);
    // R4: ACK hands over
    byteDone = 1; rxAckBit = 0; step(); idle();
    check("R4 ack shiftData", shiftData, 8'h5A);
    check("R4 ack txEmpty", {7'd0, txEmpty}, 8'd1);
    // R5: master, empty slot -> no load; slave triggers ignored
    masterMode = 1; byteStart = 1; addrHit = 1; rwRead = 1; step(); idle();
    check("R5 empty no load", {7'd0, shiftLoad}, 8'd0);
    cpuWrData = 8'h33; cpuWrEn = 1; step(); idle();
    // R6: collision in master mode
    cpuWrData = 8'hC4; cpuWrEn = 1; byteStart = 1; step(); idle();
    check("R6 old byte", shiftData, 8'h33);
    check("R6 txEmpty", {7'd0, txEmpty}, 8'd0);
    byteStart = 1; step(); idle();
    check("R6 new byte kept", shiftData, 8'hC4);
    masterMode = 0;
    // R7/R9/R8: receive path
    rxByte = 8'h91; rxValid = 1; step(); idle();
    check("R7 rxData", rxData, 8'h91);
    rxByte = 8'h22; rxValid = 1; step(); idle();
    check("R9 overrun", {7'd0, rxOverrun}, 8'd1);
    check("R9 data kept", rxData, 8'h91);
    cpuRdEn = 1; step(); idle();
    check("R8 rxFull", {7'd0, rxFull}, 8'd0);
    // R10: disabled
    modEn = 0; cpuWrData = 8'h77; cpuWrEn = 1; rxValid = 1; rxByte = 8'h66;
    addrHit = 1; rwRead = 1; step(); idle();
    check("R10 shiftLoad", {7'd0, shiftLoad}, 8'd0);
    check("R10 rxFull", {7'd0, rxFull}, 8'd0);
    modEn = 1; addrHit = 1; rwRead = 1; step(); idle();
    check("R10 byte untouched", shiftData, 8'hC4);
    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      modEn      = ($urandom % 16) != 0;
      if ($urandom % 64 == 0) masterMode = ~masterMode;
      cpuWrEn    = ($urandom % 4) == 0;
      cpuWrData  = 8'($urandom);
      cpuRdEn    = ($urandom % 4) == 0;
      addrHit    = ($urandom % 8) == 0;
      rwRead     = $urandom % 2;
      byteDone   = ($urandom % 5) == 0;
      rxAckBit   = ($urandom % 3) == 0;
      byteStart  = ($urandom % 5) == 0;
      rxValid    = ($urandom % 4) == 0;
      rxByte     = 8'($urandom);
      step();
    end
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule